// File: doc/BRIEF.md
# SIMD Rounding Shift-Accumulate Unit

This block works on one packed vector of `VEC_W` bits. Each signed lane of a source vector is shifted right arithmetically, with rounding to nearest, and the rounded value is added to the matching lane of an addend vector. A single 7-bit operand selects both the lane width and the shift distance. That operand is a 4-bit size field followed by a 3-bit low immediate. The unit is unpredicated, so every lane is written.

The unit has one register stage. A valid strobe goes in with the operands, and one cycle later the result, a matching valid strobe and an illegal-encoding flag come out. If the size field is reserved, the addend passes through unchanged and the flag is raised. The block is meant for a vector execution pipe. The register file, predication and instruction fetch are outside it.

Top module: `rshacc_unit`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `valid_o`, `illegal_o` and `result_o` read zero until the first accepted operation.
- R2: The lane width is 8 bits when `tsize_i` matches 0001, 16 bits for 001x, 32 bits for 01xx and 64 bits for 1xxx.
- R3: The shift distance is twice the lane width minus the unsigned 7-bit value `{tsize_i, imm3_i}`, with `tsize_i` in the upper four bits. For every legal encoding it lies in the range 1 to the lane width.
- R4: Each source lane is read as signed. It is increased by 2^(shift-1) at one bit wider than the lane, then shifted right with sign fill. No overflow occurs, even when the source is the most positive value and the shift is 1.
- R5: When the shift equals the lane width, the rounded contribution of every lane is zero, so each result lane equals its addend lane.
- R6: The low lane-width bits of the rounded value are added to the addend lane modulo 2^width, and the sum wraps with no saturation.
- R7: All `VEC_W`/width lanes are updated. Lane e occupies bits `[e*width +: width]` of every vector port.
- R8: A `tsize_i` of 0000 sets `illegal_o` and makes `result_o` equal to the captured `addend_i`.
- R9: `valid_o` repeats `valid_i` one cycle later. `result_o` and `illegal_o` belong to the operation that was presented with `valid_i` in the previous cycle.
- R10: While `valid_i` is low, `result_o` and `illegal_o` keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands present this cycle |
| src_i | input | VEC_W | Source vector of signed lanes |
| addend_i | input | VEC_W | Addend (accumulator) vector |
| tsize_i | input | 4 | Size field, upper part of the immediate |
| imm3_i | input | 3 | Low immediate bits |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | VEC_W | Accumulated vector |
| illegal_o | output | 1 | Reserved size field seen |

## Verification
The hardest case is the rounding carry at the edge of the lane's range. This needs a most-positive source lane with a shift of 1, or a shift equal to the lane width, and both require the largest or smallest immediate for a given size field. Uniform random immediates reach them only rarely. Directed cases therefore drive both ends of the shift range for all four lane widths, using saturated source patterns and addends that force the accumulate to wrap. Seeded random traffic then covers the interior shifts, reserved encodings and idle gaps.

// File: rtl/rshacc_pkg.sv
package rshacc_pkg;
  localparam int SHIFT_W = 7;

  typedef enum logic [1:0] {
    ESZ_B = 2'd0,
    ESZ_H = 2'd1,
    ESZ_W = 2'd2,
    ESZ_D = 2'd3
  } esz_e;

  function automatic logic [7:0] esz_bits(input esz_e esz);
    return 8'd8 << esz;
  endfunction
endpackage

// File: rtl/rshacc_decode.sv
module rshacc_decode
  import rshacc_pkg::*;
(
  input  logic [3:0]         tsize_i,
  input  logic [2:0]         imm3_i,
  output esz_e               esz_o,
  output logic [SHIFT_W-1:0] shift_o,
  output logic               illegal_o
);
  logic [7:0] diff;

  always_comb begin
    casez (tsize_i)
      4'b1???: esz_o = ESZ_D;
      4'b01??: esz_o = ESZ_W;
      4'b001?: esz_o = ESZ_H;
      default: esz_o = ESZ_B;
    endcase
    illegal_o = (tsize_i == 4'd0);
    diff      = (esz_bits(esz_o) << 1) - {1'b0, tsize_i, imm3_i};
    shift_o   = illegal_o ? SHIFT_W'(1) : diff[SHIFT_W-1:0];
  end

  always_comb begin
    // R3
    if (!illegal_o) begin
      shift_range_chk: assert (shift_o >= SHIFT_W'(1) &&
                               {1'b0, shift_o} <= esz_bits(esz_o))
        else $error("shift out of range");
    end
  end
endmodule

// File: rtl/rshacc_lane.sv
module rshacc_lane
  import rshacc_pkg::*;
#(
  parameter int ESIZE = 8
) (
  input  logic [ESIZE-1:0]   src_i,
  input  logic [ESIZE-1:0]   add_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [ESIZE-1:0]   sum_o
);
  localparam int EXT_W = ESIZE + 1;

  logic signed [EXT_W-1:0] ext, bias, rnd, shr;

  always_comb begin
    ext   = $signed({src_i[ESIZE-1], src_i});
    // one guard bit absorbs the rounding carry
    bias  = $signed(EXT_W'(1) << (shift_i - SHIFT_W'(1)));
    rnd   = ext + bias;
    shr   = rnd >>> shift_i;
    sum_o = add_i + shr[ESIZE-1:0];
  end

  always_comb begin
    // R5
    if (shift_i == SHIFT_W'(ESIZE)) begin
      full_shift_zero_chk: assert (shr == '0)
        else $error("full-width shift left nonzero residue");
    end
  end
endmodule

// File: rtl/rshacc_unit.sv
module rshacc_unit
  import rshacc_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [VEC_W-1:0] src_i,
  input  logic [VEC_W-1:0] addend_i,
  input  logic [3:0]       tsize_i,
  input  logic [2:0]       imm3_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] result_o,
  output logic             illegal_o
);
  localparam int N_SIZES = 4;

  esz_e               esz;
  logic [SHIFT_W-1:0] shift;
  logic               illegal;
  logic [VEC_W-1:0]   res_by_size [N_SIZES];
  logic [VEC_W-1:0]   result_d;

  rshacc_decode u_decode (
    .tsize_i  (tsize_i),
    .imm3_i   (imm3_i),
    .esz_o    (esz),
    .shift_o  (shift),
    .illegal_o(illegal)
  );

  for (genvar g = 0; g < N_SIZES; g++) begin : g_size
    localparam int ES = 8 << g;
    localparam int NL = VEC_W / ES;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      rshacc_lane #(.ESIZE(ES)) u_lane (
        .src_i  (src_i[l*ES +: ES]),
        .add_i  (addend_i[l*ES +: ES]),
        .shift_i(shift),
        .sum_o  (res_by_size[g][l*ES +: ES])
      );
    end
  end

  always_comb begin
    result_d = illegal ? addend_i : res_by_size[esz];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
      result_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        illegal_o <= illegal;
        result_o  <= result_d;
      end
    end
  end

  // R9
  valid_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o)
    else $error("valid_o did not follow valid_i");

  // R8
  illegal_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && tsize_i == 4'd0) |=> (illegal_o && result_o == $past(addend_i)))
    else $error("reserved encoding did not pass addend");

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(illegal_o) && !valid_o))
    else $error("outputs moved while idle");
endmodule

// File: tb/rshacc_unit_tb.sv
module rshacc_unit_tb;
  localparam int VW = 128;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [VW-1:0] src_i = '0;
  logic [VW-1:0] addend_i = '0;
  logic [3:0]    tsize_i = 4'd0;
  logic [2:0]    imm3_i = 3'd0;
  logic          valid_o;
  logic [VW-1:0] result_o;
  logic          illegal_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  rshacc_unit #(.VEC_W(VW)) u_dut (
    .clk_i, .rst_ni, .valid_i, .src_i, .addend_i, .tsize_i, .imm3_i,
    .valid_o, .result_o, .illegal_o
  );

  function automatic logic [VW-1:0] model(input logic [VW-1:0] s, a,
                                          input logic [3:0] ts, input logic [2:0] im);
    int es, sh, nl;
    logic [VW-1:0] r;
    if (ts == 4'd0) return a;
    es = ts[3] ? 64 : ts[2] ? 32 : ts[1] ? 16 : 8;
    sh = 2 * es - int'({ts, im});
    nl = VW / es;
    r  = '0;
    for (int e = 0; e < nl; e++) begin
      logic signed [66:0] v;
      logic [63:0] ls, la, acc;
      ls = '0; la = '0;
      for (int b = 0; b < es; b++) begin
        ls[b] = s[e*es+b];
        la[b] = a[e*es+b];
      end
      for (int b = 0; b < 67; b++) v[b] = (b < es) ? ls[b] : ls[es-1];
      v   = (v + (67'sd1 <<< (sh - 1))) >>> sh;
      acc = la + v[63:0];
      for (int b = 0; b < es; b++) r[e*es+b] = acc[b];
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic [VW-1:0] s, a, input logic [3:0] ts,
                    input logic [2:0] im, input string req, input bit hold);
    logic [VW-1:0] exp;
    logic          exp_ill;
    exp     = model(s, a, ts, im);
    exp_ill = (ts == 4'd0);
    @(negedge clk_i);
    valid_i = 1'b1; src_i = s; addend_i = a; tsize_i = ts; imm3_i = im;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(valid_o == 1'b1, "R9 valid", VW'(valid_o), VW'(1));
    chk(illegal_o == exp_ill, {req, " illegal"}, VW'(illegal_o), VW'(exp_ill));
    chk(result_o == exp, req, result_o, exp);
    if (hold) begin
      src_i = {4{$urandom}}; addend_i = {4{$urandom}};
      tsize_i = 4'($urandom); imm3_i = 3'($urandom);
      @(negedge clk_i);
      chk(result_o == exp && illegal_o == exp_ill && !valid_o,
          "R10 idle hold", result_o, exp);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] e;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    // R1
    chk(valid_o == 0 && illegal_o == 0 && result_o == '0, "R1 reset",
        result_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(valid_o == 0 && result_o == '0, "R1 after release", result_o, '0);

    // R2 R7: every lane +1 with shift 1 on lanes holding 2
    op({16{8'h02}}, {16{8'h10}}, 4'b0001, 3'd7, "R2 R7 byte lanes", 1);
    chk(result_o == {16{8'h11}}, "R7 byte lanes all", result_o, {16{8'h11}});
    op({8{16'h0002}}, {8{16'h1000}}, 4'b0011, 3'd7, "R2 R7 half lanes", 0);
    chk(result_o == {8{16'h1001}}, "R7 half lanes all", result_o, {8{16'h1001}});
    op({4{32'h2}}, {4{32'h7}}, 4'b0111, 3'd7, "R2 word lanes", 0);
    chk(result_o == {4{32'h8}}, "R2 word explicit", result_o, {4{32'h8}});
    op({2{64'h2}}, {2{64'h9}}, 4'b1111, 3'd7, "R2 dword lanes", 0);
    chk(result_o == {2{64'hA}}, "R2 dword explicit", result_o, {2{64'hA}});

    // R3 R5: maximum shift for every width leaves addend unchanged
    e = {4{32'hDEAD_BEEF}};
    op({16{8'h7F}}, e, 4'b0001, 3'd0, "R5 byte full shift", 0);
    chk(result_o == e, "R5 byte", result_o, e);
    op({8{16'h8000}}, e, 4'b0010, 3'd0, "R5 half full shift", 0);
    chk(result_o == e, "R5 half", result_o, e);
    op({4{32'h7FFF_FFFF}}, e, 4'b0100, 3'd0, "R5 word full shift", 0);
    op({2{64'h8000_0000_0000_0000}}, e, 4'b1000, 3'd0, "R5 dword full shift", 1);
    chk(result_o == e, "R5 dword", result_o, e);

    // R4 R6: most-positive source, shift 1 -> +64; addend 0x7F wraps to 0xBF
    op({16{8'h7F}}, {16{8'h7F}}, 4'b0001, 3'd7, "R4 R6 byte carry", 0);
    chk(result_o[7:0] == 8'hBF, "R6 byte wrap", VW'(result_o[7:0]), VW'(8'hBF));
    // R4 rounding of -3 >> 1 -> -1 ; 5 >> 2 -> 1 (5+2=7>>2)
    op({8'hFD, 8'h05}, '0, 4'b0001, 3'd7, "R4 neg round", 0);
    chk(result_o[15:8] == 8'hFF, "R4 neg round lane1", VW'(result_o[15:8]), VW'(8'hFF));
    op({16'h0, 16'h0005}, '0, 4'b0011, 3'd6, "R4 shift2", 0);
    chk(result_o[15:0] == 16'h1, "R4 shift2 lane0", VW'(result_o[15:0]), VW'(16'h1));
    op({2{64'h7FFF_FFFF_FFFF_FFFF}}, {2{64'h7FFF_FFFF_FFFF_FFFF}}, 4'b1111, 3'd7,
       "R4 R6 dword carry", 0);

    // R8
    op({4{32'h1234_5678}}, {4{32'hCAFE_F00D}}, 4'b0000, 3'd5, "R8 reserved", 1);

    // random traffic with idle gaps
    for (int i = 0; i < 400; i++) begin
      logic [3:0] ts;
      ts = ($urandom % 16 == 0) ? 4'd0 : 4'($urandom);
      op({$urandom, $urandom, $urandom, $urandom},
         {$urandom, $urandom, $urandom, $urandom},
         ts, 3'($urandom), "R3 R4 R6 random", ($urandom % 4) == 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule